// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the host-visible control state of one bus-master disk DMA channel: a command register carrying the run control and the transfer direction, a status register, and a 32-bit pointer to the first entry of the descriptor table in memory. The host reaches these registers over a simple synchronous register bus. Writes take effect at the clock edge. Reads return data one cycle after the request.

The transfer engine lives outside this block and is represented by two strobes. One reports a normal finish and the other reports a fault. The block drives the run control and the direction to the engine. It tracks the busy, fault and completion flags itself and raises an interrupt line while completion is pending.

When software stops a channel that was running, the block judges the transfer. It reports a clean end only when the channel was idle, had no fault and had completion flagged. Any other combination yields a failure code built from the status byte as it stood when the stop was written.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command byte, the status byte, the table pointer, `irq_pending`, `end_valid` and `rd_valid` are all zero.
- R2: A command write (offset 0, lane 0) stores bit 0 as the run control (`xfer_go`) and bit 3 as the direction (`dir_to_mem`, 1 = device to memory). Writing bit 0 from 0 to 1 sets the busy flag, status bit 0, at the same edge.
- R3: While the busy flag is set, a command write leaves the direction bit unchanged. When the channel is idle, the direction bit takes the written value.
- R4: A `done` pulse while busy clears busy and sets completion (status bit 2). A `fault` pulse while busy clears busy and sets both fault (status bit 1) and completion. Either pulse has no effect while idle.
- R5: In a status write (offset 2, lane 0), a 1 in bit 1 or bit 2 clears that flag and a 0 leaves it unchanged. An engine event in the same cycle wins over the clear.
- R6: Status bits 5 and 6 are plain read/write drive capability flags. Status writes do not affect bit 0, and status bits 3, 4 and 7 always read 0.
- R7: The table pointer (offset 4) is 32 bits wide and is written per byte lane through `wr_be`. Bits 1:0 always read 0, which keeps the table dword aligned.
- R8: A read request (`rd_en`) returns the addressed register on `rd_data`, with `rd_valid` high, in the cycle after the request. Unmapped offsets read 0.
- R9: A command write that clears bit 0 while it is set stops the channel and clears busy. In the next cycle `end_valid` pulses high. At the same time `end_ok` is 1 only if status bits 2:0 were 3'b100 before that write; otherwise `end_code` = 8'h10 | that status byte (and `end_code` is 0 when `end_ok` is 1).
- R10: `irq_pending` equals the completion flag (status bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte-lane enables |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| eng_done | input | 1 | Engine finished normally (pulse) |
| eng_fault | input | 1 | Engine fault (pulse) |
| xfer_go | output | 1 | Run control to the engine |
| dir_to_mem | output | 1 | Direction: 1 = device to memory |
| tbl_ptr | output | 32 | Descriptor table base address |
| irq_pending | output | 1 | Completion interrupt pending |
| end_valid | output | 1 | Stop verdict valid (one cycle) |
| end_ok | output | 1 | Transfer ended cleanly |
| end_code | output | 8 | Failure code, 0 when clean |

## Verification
On every cycle, the assertions check that:
- a start sets busy;
- direction never moves while busy;
- an engine done or fault event lands in the flags and the interrupt line;
- reads complete with one cycle of latency;
- a clean verdict always carries a zero code.

The directed scenarios are needed for the rest:
- the exact failure codes for a faulted run and for a run stopped early;
- the per-lane and alignment behaviour of the pointer;
- the rule that a set beats a clear in the same cycle;
- engine strobes being ignored while idle.

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 3'd0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 3'd2,
  parameter logic [ADDR_W-1:0] PTR_OFS  = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic              eng_done,
  input  logic              eng_fault,
  output logic              xfer_go,
  output logic              dir_to_mem,
  output logic [31:0]       tbl_ptr,
  output logic              irq_pending,
  output logic              end_valid,
  output logic              end_ok,
  output logic [7:0]        end_code
);

  localparam logic [2:0] CLEAN_FLAGS = 3'b100;

  logic       go_q, dir_q, busy_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic [31:0] ptr_q;

  logic wr_cmd, wr_stat, wr_ptr;
  logic go_rise, go_stop, eng_evt;
  logic [7:0] cmd_byte, stat_byte;

  assign wr_cmd  = wr_en && (addr == CMD_OFS)  && wr_be[0];
  assign wr_stat = wr_en && (addr == STAT_OFS) && wr_be[0];
  assign wr_ptr  = wr_en && (addr == PTR_OFS);

  assign go_rise = wr_cmd && !go_q &&  wr_data[0];
  assign go_stop = wr_cmd &&  go_q && !wr_data[0];
  assign eng_evt = busy_q && (eng_done || eng_fault);

  assign cmd_byte  = {4'b0, dir_q, 2'b0, go_q};
  assign stat_byte = {1'b0, cap_q, 2'b0, irq_q, err_q, busy_q};

  // command register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      dir_q <= 1'b0;
    end else if (wr_cmd) begin
      go_q <= wr_data[0];
      if (!busy_q) dir_q <= wr_data[3];
    end
  end

  // busy flag follows the engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (go_rise) busy_q <= 1'b1;
    else if (go_stop) busy_q <= 1'b0;
    else if (eng_evt) busy_q <= 1'b0;
  end

  // sticky flags, set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (busy_q && eng_fault)            err_q <= 1'b1;
      else if (wr_stat && wr_data[1])     err_q <= 1'b0;
      if (eng_evt)                        irq_q <= 1'b1;
      else if (wr_stat && wr_data[2])     irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= 2'b0;
    else if (wr_stat) cap_q <= wr_data[6:5];
  end

  // descriptor table pointer, per-lane writes
  for (genvar b = 0; b < 4; b++) begin : g_ptr_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_q[8*b +: 8] <= 8'h0;
      else if (wr_ptr && wr_be[b]) ptr_q[8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  // end-of-transfer verdict
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_valid <= 1'b0;
      end_ok    <= 1'b0;
      end_code  <= 8'h0;
    end else begin
      end_valid <= go_stop;
      if (go_stop) begin
        end_ok   <= (stat_byte[2:0] == CLEAN_FLAGS);
        end_code <= (stat_byte[2:0] == CLEAN_FLAGS) ? 8'h00 : (8'h10 | stat_byte);
      end
    end
  end

  // read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (addr == CMD_OFS)       rd_data <= {24'h0, cmd_byte};
        else if (addr == STAT_OFS) rd_data <= {24'h0, stat_byte};
        else if (addr == PTR_OFS)  rd_data <= {ptr_q[31:2], 2'b00};
        else                       rd_data <= 32'h0;
      end
    end
  end

  assign xfer_go     = go_q;
  assign dir_to_mem  = dir_q;
  assign tbl_ptr     = {ptr_q[31:2], 2'b00};
  assign irq_pending = irq_q;

  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_go) |-> stat_byte[0]);

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(dir_to_mem));

  assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eng_done && !go_stop) |=> (!busy_q && irq_pending));

  assert_fault_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eng_fault) |=> (err_q && irq_pending));

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_clean_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_ok) |-> (end_code == 8'h00));

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |-> !busy_q);

endmodule

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, eng_done = 0, eng_fault = 0;
  logic [2:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] rd_data, tbl_ptr;
  logic rd_valid, xfer_go, dir_to_mem, irq_pending, end_valid, end_ok;
  logic [7:0] end_code;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bmdma_regs i_bmdma_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data), .rd_valid(rd_valid),
    .eng_done(eng_done), .eng_fault(eng_fault), .xfer_go(xfer_go),
    .dir_to_mem(dir_to_mem), .tbl_ptr(tbl_ptr), .irq_pending(irq_pending),
    .end_valid(end_valid), .end_ok(end_ok), .end_code(end_code));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 0; wr_be = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic pulse(bit fault);
    @(negedge clk);
    if (fault) eng_fault = 1; else eng_done = 1;
    @(negedge clk);
    eng_fault = 0; eng_done = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 end_valid", end_valid, 0);
    check("R1 irq", irq_pending, 0);
    rd(3'd0, d); check("R1 cmd", d, 0);
    rd(3'd2, d); check("R1 stat", d, 0);
    rd(3'd4, d); check("R1 ptr", d, 0);
  endtask

  task automatic t_read_latency;
    @(negedge clk);
    rd_en = 1; addr = 3'd6;
    @(negedge clk);
    rd_en = 0;
    check("R8 rd_valid", rd_valid, 1);
    check("R8 unmapped", rd_data, 0);
    @(negedge clk);
    check("R8 rd_valid drop", rd_valid, 0);
  endtask

  task automatic t_pointer;
    logic [31:0] d;
    wr(3'd4, 32'h12345677, 4'hF);
    rd(3'd4, d); check("R7 ptr full", d, 32'h12345674);
    wr(3'd4, 32'h0000AB00, 4'b0010);
    rd(3'd4, d); check("R7 ptr lane", d, 32'h1234AB74);
    check("R7 ptr port", tbl_ptr, 32'h1234AB74);
  endtask

  task automatic t_caps;
    logic [31:0] d;
    wr(3'd2, 32'h20, 4'h1);
    rd(3'd2, d); check("R6 cap0", d, 32'h20);
    wr(3'd2, 32'hFF, 4'h1);
    rd(3'd2, d); check("R6 caps/ro bits", d, 32'h60);
  endtask

  task automatic t_clean;
    logic [31:0] d;
    wr(3'd0, 32'h08, 4'h1);
    check("R2 dir", dir_to_mem, 1);
    wr(3'd0, 32'h09, 4'h1);
    check("R2 go", xfer_go, 1);
    rd(3'd2, d); check("R2 busy", d, 32'h61);
    wr(3'd0, 32'h01, 4'h1);
    rd(3'd0, d); check("R3 dir held", d, 32'h09);
    pulse(0);
    rd(3'd2, d); check("R4 done", d, 32'h64);
    check("R10 irq", irq_pending, 1);
    wr(3'd0, 32'h08, 4'h1);
    check("R9 valid", end_valid, 1);
    check("R9 ok", end_ok, 1);
    check("R9 code", end_code, 0);
    @(negedge clk);
    check("R9 pulse", end_valid, 0);
    wr(3'd2, 32'h64, 4'h1);
    rd(3'd2, d); check("R5 w1c", d, 32'h60);
    check("R10 irq clr", irq_pending, 0);
  endtask

  task automatic t_fault;
    logic [31:0] d;
    wr(3'd0, 32'h09, 4'h1);
    pulse(1);
    rd(3'd2, d); check("R4 fault", d, 32'h66);
    wr(3'd0, 32'h08, 4'h1);
    check("R9 fault ok", end_ok, 0);
    check("R9 fault code", end_code, 8'h76);
    wr(3'd2, 32'h64, 4'h1);
    rd(3'd2, d); check("R5 irq only", d, 32'h62);
    wr(3'd2, 32'h62, 4'h1);
    rd(3'd2, d); check("R5 err clr", d, 32'h60);
  endtask

  task automatic t_early_stop;
    logic [31:0] d;
    wr(3'd0, 32'h01, 4'h1);
    check("R3 dir idle", dir_to_mem, 0);
    wr(3'd0, 32'h00, 4'h1);
    check("R9 early ok", end_ok, 0);
    check("R9 early code", end_code, 8'h71);
    rd(3'd2, d); check("R9 stop clears busy", d, 32'h60);
  endtask

  task automatic t_idle_ignore;
    logic [31:0] d;
    pulse(0);
    pulse(1);
    rd(3'd2, d); check("R4 idle ignore", d, 32'h60);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(3'd0, 32'h01, 4'h1);
    @(negedge clk);
    wr_en = 1; addr = 3'd2; wr_data = 32'h66; wr_be = 4'h1; eng_done = 1;
    @(negedge clk);
    wr_en = 0; wr_be = '0; eng_done = 0;
    rd(3'd2, d); check("R5 set wins", d, 32'h64);
    wr(3'd0, 32'h00, 4'h1);
    wr(3'd2, 32'h04, 4'h1);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_latency();
    t_pointer();
    t_caps();
    t_clean();
    t_fault();
    t_early_stop();
    t_idle_ignore();
    t_race();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule